// File: doc/BRIEF.md
# TLB Special-Register Access Unit

This unit sits beside a processor's special-register path and gives software its only window into a software-managed translation buffer. It holds an index register, an 8-bit process-ID register, two banks of 64-bit entries and an array of 8-bit tag IDs, one per entry. One bank holds the high-word entry and the other holds the low-word entry. Move-to and move-from requests come in on a 32-bit port with a special-register number, a direction, a data word and an extended flag. The extended flag reaches the upper 32 bits of a 64-bit low-word entry.

Each request is handled in the cycle it arrives. The response appears on the next cycle through a small response state machine. Its states are `ST_IDLE` (no request last cycle), `ST_READ` (read data valid), `ST_WRITE` (plain write done), `ST_FLUSH` (a high-word entry was rewritten and its index is being invalidated), `ST_REJ_RD` (rejected extended read) and `ST_REJ_WR` (rejected extended write). The next state depends only on the request in the current cycle, so there is a transition from every state to every state:
- no request, or a register number outside the window, goes to `ST_IDLE`;
- a legal read goes to `ST_READ`;
- a legal write goes to `ST_FLUSH` if it targets the high word, and to `ST_WRITE` otherwise;
- an illegal extended access goes to `ST_REJ_RD` or `ST_REJ_WR`, depending on its direction.

A combinational helper pulls the extended bit out of a 32-bit instruction immediate.

Top module: `tlbsr_unit`

## Requirements
- R1: A request is handled only when bits 13:8 of its register number equal 0x10. Other requests give no response and change no state. Bits 2:0 select the register: 0 is the process ID, 2 the index, 3 the low word and 4 the high word. Reads of the other codes return 0, and writes to them change nothing.
- R2: The index register reads back the full 32-bit value written. Its low 8 bits pick the entry for every low-word and high-word access.
- R3: A normal read of the low word (code 3, odd) returns bits 31:0 of the low-word bank entry. A normal read of the high word (code 4, even) returns bits 31:0 of the high-word bank entry.
- R4: An extended read of the low word returns bits 63:32 of the indexed low-word entry.
- R5: A write to the low or high word replaces only one half of the indexed entry: bits 63:32 when extended, bits 31:0 otherwise. The other half keeps its value.
- R6: An extended access to any code other than 3 is rejected. A rejected read returns 0 with read-valid set, and a rejected write changes no state. In both cases the error output is high for exactly the following cycle.
- R7: A read of the high word also loads the process-ID register from the tag ID of the indexed entry.
- R8: A write of the high word stores the process-ID register into the tag ID of the indexed entry. On the next cycle it raises the flush output for one cycle, with the index on the flush-index output.
- R9: The decoded extended bit is immediate bit 19 for move-from (direction 0) and immediate bit 24 for move-to (direction 1). It is 0 whenever ADDR_WIDTH is 32 or less.
- R10: With HAS_MMU = 0, reads still return read-valid but with data 0. Writes change nothing, and the flush and error outputs never rise.
- R11: Read data is valid exactly one cycle after the read request. A read in the cycle right after a write to the same entry returns the written value.
- R12: After reset all outputs are low, the index and process-ID registers are 0, and every entry and tag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 for move-to (write), 0 for move-from (read) |
| req_spr | input | 14 | Special-register number |
| req_ext | input | 1 | Extended (upper-half) access flag |
| req_wdata | input | 32 | Write data |
| dec_imm | input | 32 | Instruction immediate for extended-bit decoding |
| dec_to | input | 1 | Direction of the instruction being decoded |
| dec_ext | output | 1 | Decoded extended bit |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| flush_valid | output | 1 | Invalidate pulse for one entry |
| flush_index | output | 8 | Entry index being invalidated |
| err_pulse | output | 1 | Rejected extended access |

## Verification
The hardest case to reach from the ports is an interaction between the two halves of one entry. An extended write followed by a normal write must leave both halves intact. The next access must also see the newest data in the very next cycle. Random index values are therefore confined to a few entries, so halves and tags are revisited often and hazards between consecutive writes and reads happen naturally. Directed sequences add illegal extended accesses in between and check that they leave the stored state untouched. A second instance with no MMU and a 32-bit address width shares the same stimulus, so every request also exercises the silent configuration and the forced-zero decoder.

// File: rtl/tlbsr_pkg.sv
package tlbsr_pkg;

    localparam int WORD_W       = 32;
    localparam int SPR_W        = 14;
    localparam int IMM_W        = 32;
    localparam int EXT_BIT_FROM = 19;
    localparam int EXT_BIT_TO   = 24;

    localparam logic [5:0] SPR_PAGE   = 6'h10;
    localparam logic [2:0] SEL_PID    = 3'd0;
    localparam logic [2:0] SEL_INDEX  = 3'd2;
    localparam logic [2:0] SEL_LOWORD = 3'd3;
    localparam logic [2:0] SEL_HIWORD = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_FLUSH,
        ST_REJ_RD,
        ST_REJ_WR
    } resp_state_t;

    typedef struct packed {
        logic       hit;
        logic       reject;
        logic       rd_any;
        logic       rd_ok;
        logic       wr_ok;
        logic       ram;
        logic       bank_lo;
        logic       upper;
        logic [2:0] sel;
    } spr_cls_t;

endpackage

// File: rtl/tlbsr_ext_decode.sv
module tlbsr_ext_decode
    import tlbsr_pkg::*;
#(
    parameter int ADDR_WIDTH = 64
) (
    input  logic [IMM_W-1:0] imm,
    input  logic             to,
    output logic             ext
);

    logic unused_dec;

    generate
        if (ADDR_WIDTH > 32) begin : g_wide
            assign ext        = to ? imm[EXT_BIT_TO] : imm[EXT_BIT_FROM];
            assign unused_dec = ^imm;
        end else begin : g_narrow
            assign ext        = 1'b0;
            assign unused_dec = ^{imm, to};
        end
    endgenerate

endmodule

// File: rtl/tlbsr_classify.sv
module tlbsr_classify
    import tlbsr_pkg::*;
#(
    parameter bit HAS_MMU    = 1'b1,
    parameter int ADDR_WIDTH = 64
) (
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [SPR_W-1:0] req_spr,
    input  logic             req_ext,
    output spr_cls_t         cls
);

    localparam bit EXT_OK = (ADDR_WIDTH > 32);

    logic       hit;
    logic       ext_eff;
    logic       reject;
    logic       active;
    logic [2:0] sel;
    logic       unused_spr;

    assign unused_spr = ^req_spr[7:3];
    assign sel        = req_spr[2:0];
    assign ext_eff    = EXT_OK ? req_ext : 1'b0;
    assign hit        = req_valid && (req_spr[SPR_W-1:8] == SPR_PAGE);
    assign reject     = hit && HAS_MMU && ext_eff && (sel != SEL_LOWORD);
    assign active     = hit && HAS_MMU && !reject;

    always_comb begin
        cls         = '0;
        cls.hit     = hit;
        cls.reject  = reject;
        cls.rd_any  = hit && !req_write;
        cls.rd_ok   = active && !req_write;
        cls.wr_ok   = active && req_write;
        cls.ram     = active && ((sel == SEL_LOWORD) || (sel == SEL_HIWORD));
        cls.bank_lo = sel[0];
        cls.upper   = ext_eff;
        cls.sel     = sel;
    end

endmodule

// File: rtl/tlbsr_entry_store.sv
module tlbsr_entry_store
    import tlbsr_pkg::*;
#(
    parameter int INDEX_W = 8,
    parameter int TAG_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] idx,
    input  logic               bank_lo,
    input  logic               upper,
    input  logic               wr_en,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               tag_we,
    input  logic [TAG_W-1:0]   tag_wdata,
    output logic [WORD_W-1:0]  rd_word,
    output logic [TAG_W-1:0]   rd_tag
);

    localparam int ENTRIES = 1 << INDEX_W;
    localparam int BANKS   = 2;
    localparam int HALVES  = 2;

    logic [WORD_W-1:0] half_rd [BANKS*HALVES];
    logic [TAG_W-1:0]  tag_mem [ENTRIES];

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            for (genvar h = 0; h < HALVES; h++) begin : g_half
                logic [WORD_W-1:0] mem [ENTRIES];
                logic              sel_here;

                assign sel_here = (bank_lo == 1'(b)) && (upper == 1'(h));

                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
                    end else if (wr_en && sel_here) begin
                        mem[idx] <= wr_data;
                    end
                end

                assign half_rd[b*HALVES + h] = mem[idx];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) tag_mem[e] <= '0;
        end else if (tag_we) begin
            tag_mem[idx] <= tag_wdata;
        end
    end

    assign rd_word = half_rd[{bank_lo, upper}];
    assign rd_tag  = tag_mem[idx];

endmodule

// File: rtl/tlbsr_unit.sv
module tlbsr_unit
    import tlbsr_pkg::*;
#(
    parameter bit HAS_MMU    = 1'b1,
    parameter int ADDR_WIDTH = 64,
    parameter int INDEX_W    = 8,
    parameter int TAG_W      = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [SPR_W-1:0]   req_spr,
    input  logic               req_ext,
    input  logic [WORD_W-1:0]  req_wdata,
    input  logic [IMM_W-1:0]   dec_imm,
    input  logic               dec_to,
    output logic               dec_ext,
    output logic               rd_valid,
    output logic [WORD_W-1:0]  rd_data,
    output logic               flush_valid,
    output logic [INDEX_W-1:0] flush_index,
    output logic               err_pulse
);

    spr_cls_t           cls;
    resp_state_t        state_q, state_d;
    logic [WORD_W-1:0]  index_q;
    logic [TAG_W-1:0]   pid_q;
    logic [WORD_W-1:0]  rd_data_q;
    logic [WORD_W-1:0]  rd_mux;
    logic [INDEX_W-1:0] flush_idx_q;
    logic [INDEX_W-1:0] entry_idx;
    logic [WORD_W-1:0]  store_word;
    logic [TAG_W-1:0]   store_tag;
    logic               hi_write;

    tlbsr_ext_decode #(.ADDR_WIDTH(ADDR_WIDTH)) u_ext_decode (
        .imm (dec_imm),
        .to  (dec_to),
        .ext (dec_ext)
    );

    tlbsr_classify #(.HAS_MMU(HAS_MMU), .ADDR_WIDTH(ADDR_WIDTH)) u_classify (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_spr   (req_spr),
        .req_ext   (req_ext),
        .cls       (cls)
    );

    assign entry_idx = index_q[INDEX_W-1:0];
    assign hi_write  = cls.wr_ok && (cls.sel == SEL_HIWORD);

    tlbsr_entry_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (entry_idx),
        .bank_lo   (cls.bank_lo),
        .upper     (cls.upper),
        .wr_en     (cls.wr_ok && cls.ram),
        .wr_data   (req_wdata),
        .tag_we    (hi_write),
        .tag_wdata (pid_q),
        .rd_word   (store_word),
        .rd_tag    (store_tag)
    );

    always_comb begin
        rd_mux = '0;
        if (cls.rd_ok) begin
            case (cls.sel)
                SEL_PID:    rd_mux = WORD_W'(pid_q);
                SEL_INDEX:  rd_mux = index_q;
                SEL_LOWORD: rd_mux = store_word;
                SEL_HIWORD: rd_mux = store_word;
                default:    rd_mux = '0;
            endcase
        end
    end

    always_comb begin
        state_d = ST_IDLE;
        if (!cls.hit)         state_d = ST_IDLE;
        else if (cls.reject)  state_d = req_write ? ST_REJ_WR : ST_REJ_RD;
        else if (!req_write)  state_d = ST_READ;
        else if (hi_write)    state_d = ST_FLUSH;
        else                  state_d = ST_WRITE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            index_q     <= '0;
            pid_q       <= '0;
            rd_data_q   <= '0;
            flush_idx_q <= '0;
        end else begin
            state_q <= state_d;
            if (cls.wr_ok && (cls.sel == SEL_INDEX)) index_q <= req_wdata;
            if (cls.wr_ok && (cls.sel == SEL_PID))
                pid_q <= req_wdata[TAG_W-1:0];
            else if (cls.rd_ok && (cls.sel == SEL_HIWORD))
                pid_q <= store_tag;
            if (cls.rd_any) rd_data_q <= rd_mux;
            if (hi_write) flush_idx_q <= entry_idx;
        end
    end

    always_comb begin
        rd_valid    = 1'b0;
        rd_data     = '0;
        flush_valid = 1'b0;
        err_pulse   = 1'b0;
        flush_index = flush_idx_q;
        unique case (state_q)
            ST_IDLE:   ;
            ST_WRITE:  ;
            ST_READ: begin
                rd_valid = 1'b1;
                rd_data  = rd_data_q;
            end
            ST_REJ_RD: begin
                rd_valid  = 1'b1;
                rd_data   = rd_data_q;
                err_pulse = 1'b1;
            end
            ST_REJ_WR: err_pulse = 1'b1;
            ST_FLUSH:  flush_valid = 1'b1;
            default:   ;
        endcase
    end

    // R6: a rejected read never returns data
    assert_reject_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_pulse && rd_valid) |-> (rd_data == '0));

    // R6: error follows an extended request to a register other than the low word
    assert_reject_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $past(req_valid && req_ext && (req_spr[2:0] != SEL_LOWORD)));

    // R8: flush only follows a write to the high word
    assert_flush_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> $past(req_valid && req_write && (req_spr[2:0] == SEL_HIWORD)));

    // R11: read response exactly one cycle after a read request
    assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(req_valid && !req_write));

    assert_outcome_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush_valid && err_pulse));

    generate
        if (!HAS_MMU) begin : g_nommu_chk
            // R10: a core without an MMU stays silent
            assert_nommu_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !flush_valid && !err_pulse && (rd_data == '0));
        end
    endgenerate

endmodule

// File: tb/test_tlbsr_unit.sv
`timescale 1ns/1ps
module test_tlbsr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [13:0] req_spr = '0;
    logic        req_ext = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [31:0] dec_imm = '0;
    logic        dec_to = 1'b0;

    logic        dec_ext, rd_valid, flush_valid, err_pulse;
    logic [31:0] rd_data;
    logic [7:0]  flush_index;
    logic        n_dec_ext, n_rd_valid, n_flush_valid, n_err_pulse;
    logic [31:0] n_rd_data;
    logic [7:0]  n_flush_index;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [63:0] m_lo  [256];
    logic [63:0] m_hi  [256];
    logic [7:0]  m_tag [256];
    logic [31:0] m_index;
    logic [7:0]  m_pid;

    always #2 clk = ~clk;

    tlbsr_unit #(.HAS_MMU(1'b1), .ADDR_WIDTH(64)) i_tlbsr_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_spr(req_spr), .req_ext(req_ext), .req_wdata(req_wdata),
        .dec_imm(dec_imm), .dec_to(dec_to), .dec_ext(dec_ext),
        .rd_valid(rd_valid), .rd_data(rd_data), .flush_valid(flush_valid),
        .flush_index(flush_index), .err_pulse(err_pulse)
    );

    tlbsr_unit #(.HAS_MMU(1'b0), .ADDR_WIDTH(32)) i_tlbsr_unit_nommu (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_spr(req_spr), .req_ext(req_ext), .req_wdata(req_wdata),
        .dec_imm(dec_imm), .dec_to(dec_to), .dec_ext(n_dec_ext),
        .rd_valid(n_rd_valid), .rd_data(n_rd_data), .flush_valid(n_flush_valid),
        .flush_index(n_flush_index), .err_pulse(n_err_pulse)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic string tag_of(input bit wr, input logic [13:0] spr, input bit ext);
        logic [2:0] s = spr[2:0];
        if (spr[13:8] != 6'h10)        return "R1";
        if (ext && s != 3'd3)          return "R6";
        if (s == 3'd4)                 return wr ? "R8" : "R7";
        if (s == 3'd2 || s == 3'd0)    return "R2";
        if (s != 3'd3)                 return "R1";
        if (ext)                       return wr ? "R5" : "R4";
        return wr ? "R5" : "R3";
    endfunction

    // Drive one request, then check its response one cycle later.
    task automatic req(input bit wr, input logic [13:0] spr, input bit ext,
                       input logic [31:0] wd);
        bit          hit = (spr[13:8] == 6'h10);
        logic [2:0]  s = spr[2:0];
        bit          rej = hit && ext && (s != 3'd3);
        bit          e_rv = hit && !wr;
        bit          e_fl = hit && wr && !rej && (s == 3'd4);
        logic [7:0]  i = m_index[7:0];
        logic [31:0] e_rd = '0;
        string       t = tag_of(wr, spr, ext);
        if (hit && !rej) begin
            if (!wr) begin
                case (s)
                    3'd0: e_rd = {24'h0, m_pid};
                    3'd2: e_rd = m_index;
                    3'd3: e_rd = ext ? m_lo[i][63:32] : m_lo[i][31:0];
                    3'd4: begin e_rd = m_hi[i][31:0]; m_pid = m_tag[i]; end
                    default: e_rd = '0;
                endcase
            end else begin
                case (s)
                    3'd0: m_pid = wd[7:0];
                    3'd2: m_index = wd;
                    3'd3: if (ext) m_lo[i][63:32] = wd; else m_lo[i][31:0] = wd;
                    3'd4: begin m_hi[i][31:0] = wd; m_tag[i] = m_pid; end
                    default: ;
                endcase
            end
        end
        req_valid = 1'b1; req_write = wr; req_spr = spr; req_ext = ext; req_wdata = wd;
        @(negedge clk);
        chk(rd_valid == e_rv, {t, " rd_valid"}, 64'(rd_valid), 64'(e_rv));
        if (e_rv) chk(rd_data == e_rd, {t, " rd_data"}, 64'(rd_data), 64'(e_rd));
        chk(err_pulse == rej, {t, " err"}, 64'(err_pulse), 64'(rej));
        chk(flush_valid == e_fl, {t, " flush"}, 64'(flush_valid), 64'(e_fl));
        if (e_fl) chk(flush_index == i, "R8 flush_index", 64'(flush_index), 64'(i));
        chk(n_rd_valid == e_rv, "R10 nommu rd_valid", 64'(n_rd_valid), 64'(e_rv));
        chk(n_rd_data == 0 && !n_flush_valid && !n_err_pulse, "R10 nommu quiet",
            {n_rd_data, 30'h0, n_flush_valid, n_err_pulse}, 64'h0);
    endtask

    task automatic idle();
        req_valid = 1'b0; req_ext = 1'b0;
        @(negedge clk);
        chk(!rd_valid && !err_pulse && !flush_valid, "R11 idle quiet",
            {61'h0, rd_valid, err_pulse, flush_valid}, 64'h0);
    endtask

    initial begin
        for (int k = 0; k < 256; k++) begin m_lo[k] = '0; m_hi[k] = '0; m_tag[k] = '0; end
        m_index = '0; m_pid = '0;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(!rd_valid && !err_pulse && !flush_valid, "R12 reset outputs",
            {61'h0, rd_valid, err_pulse, flush_valid}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: registers and entry 0 cleared
        req(0, 14'h1002, 0, 0);
        req(0, 14'h1000, 0, 0);
        req(0, 14'h1003, 0, 0);
        req(0, 14'h1003, 1, 0);
        req(0, 14'h1004, 0, 0);

        // R2: index reads back in full, low 8 bits select entry
        req(1, 14'h1002, 0, 32'hABCD_0105);
        req(0, 14'h1002, 0, 0);
        // R5/R11: halves written independently, read back in consecutive cycles
        req(1, 14'h1003, 1, 32'hDEAD_BEEF);
        req(0, 14'h1003, 1, 0);
        req(1, 14'h1003, 0, 32'h1234_5678);
        req(0, 14'h1003, 0, 0);
        req(0, 14'h1003, 1, 0);
        // R8/R7: tag store and reload
        req(1, 14'h1000, 0, 32'h0000_005A);
        req(1, 14'h1004, 0, 32'hCAFE_F00D);
        req(1, 14'h1000, 0, 32'h0000_0011);
        req(0, 14'h1004, 0, 0);
        req(0, 14'h1000, 0, 0);
        // R6: illegal extended accesses leave state untouched
        req(1, 14'h1004, 1, 32'hFFFF_FFFF);
        req(0, 14'h1004, 1, 0);
        req(1, 14'h1002, 1, 32'h0000_0000);
        req(0, 14'h1002, 0, 0);
        req(0, 14'h1004, 0, 0);
        // R1: outside the window and unmapped codes
        req(1, 14'h1102, 0, 32'h0000_0077);
        req(0, 14'h0002, 0, 0);
        req(1, 14'h1005, 0, 32'h5555_5555);
        req(0, 14'h1005, 0, 0);
        req(0, 14'h1002, 0, 0);
        req(0, 14'h10FB, 0, 0);
        idle();

        // R9: decoder bit positions, forced zero on narrow core
        dec_to = 1'b0; dec_imm = 32'h0008_0000; #1;
        chk(dec_ext == 1'b1, "R9 from bit19", 64'(dec_ext), 64'h1);
        chk(n_dec_ext == 1'b0, "R9 narrow forced", 64'(n_dec_ext), 64'h0);
        dec_to = 1'b1; #1;
        chk(dec_ext == 1'b0, "R9 to ignores bit19", 64'(dec_ext), 64'h0);
        dec_imm = 32'h0100_0000; #1;
        chk(dec_ext == 1'b1, "R9 to bit24", 64'(dec_ext), 64'h1);
        chk(n_dec_ext == 1'b0, "R9 narrow forced", 64'(n_dec_ext), 64'h0);
        dec_to = 1'b0; #1;
        chk(dec_ext == 1'b0, "R9 from ignores bit24", 64'(dec_ext), 64'h0);
        @(negedge clk);

        // Random mix over a handful of entries
        for (int n = 0; n < 600; n++) begin
            logic [2:0]  s;
            logic [13:0] spr;
            bit          wr  = $urandom_range(0, 1) == 1;
            bit          ext = $urandom_range(0, 3) == 0;
            logic [31:0] wd  = $urandom();
            int          pick = $urandom_range(0, 9);
            case (pick)
                0, 1:    s = 3'd3;
                2, 3:    s = 3'd4;
                4:       s = 3'd0;
                5:       s = 3'd2;
                6:       s = 3'd1;
                7:       s = 3'd5;
                default: s = 3'd3;
            endcase
            spr = ($urandom_range(0, 15) == 0) ? {6'h12, 5'h0, s} : {6'h10, 5'h0, s};
            if (s == 3'd2 && wr) wd = (wd & 32'hFFFF_FF00) | 32'($urandom_range(0, 5));
            req(wr, spr, ext, wd);
            if ($urandom_range(0, 7) == 0) idle();
        end
        idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule